// File: doc/BRIEF.md
# Reset-Aligned Half-Rate Data Capture Strobe

This block runs entirely on a fast update clock that ticks at twice the input sample rate. From that clock it derives a half-rate phase signal, driven out as a monitor pin. It also derives an internal strobe that registers the input data bus on every second fast edge. Software and board logic upstream use the monitor pin to learn which fast edge will take their data. They change the bus in step with it.

An asynchronous reset input sets the phase to a known state, so that an external source can line its data up with a known edge. While reset is high the phase output is forced high. After reset is released it falls on the first counted edge, and from then on it toggles on every fast edge. Data is taken on the fast edge where the phase rises from low to high. A one-cycle valid flag marks each capture for downstream logic.

The release of the reset passes through a short synchronizer. That gives the phase a fixed start-up latency measured in fast edges. A parameter adds one further stage, which stands in for a release that arrives too late in a cycle to be seen by the next edge.

Top module: `halfrate_latch`

## Requirements
- R1: While `rst_async` is high, `phase_mon` is 1, `dout_valid` is 0 and `dout` is all zeros, and these values appear on reset assertion without waiting for a clock edge.
- R2: After `rst_async` falls, `phase_mon` stays 1 for exactly S rising edges of `clk_fast`, where S = 2 when `LATE_RELEASE` = 0. It goes to 0 on edge S+1.
- R3: Once it has fallen after a release, `phase_mon` inverts on every rising edge of `clk_fast` for as long as `rst_async` stays low.
- R4: On each rising edge where `phase_mon` goes from 0 to 1, `dout` takes the value `din` had at that edge. `dout` keeps that value until the next such edge.
- R5: `dout_valid` is 1 for exactly the one fast cycle that follows each capture edge, which is the cycle in which `phase_mon` has just risen. It is never high in two consecutive cycles.
- R6: A value on `din` at an edge where `phase_mon` goes from 1 to 0 is ignored: `dout` does not change at that edge.
- R7: Raising `rst_async` in the middle of operation forces the R1 values at once. The next release then restarts the phase with the same latency as in R2.
- R8: With `LATE_RELEASE` = 1 the start-up latency becomes S = 3 edges. Toggling and capture then follow R3 to R5 shifted by that one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Update clock at twice the data rate |
| rst_async | input | 1 | Asynchronous active-high phase reset |
| din | input | DATA_W | Input data bus |
| phase_mon | output | 1 | Half-rate phase monitor, rises on the capture edge |
| dout | output | DATA_W | Captured data register |
| dout_valid | output | 1 | One-cycle pulse after each capture |

## Verification
The bus changes on every fast cycle with a ramp, an alternating checkerboard, a four-step run that puts all-zeros and all-ones on the two edge types, and random words. Because the values differ from edge to edge, taking the wrong edge, or taking both edges, shows up as a wrong word or as a word that changes when it should not. Two instances, one per latency setting, receive the same stimulus, so the extra release stage is told apart from an off-by-one in the divider. Reset is raised in the middle of a stream at both phase values to show that the restart latency does not depend on where the divider was.

// File: rtl/halfrate_pkg.sv
package halfrate_pkg;

  // Number of synchronizer stages the reset release crosses.
  function automatic int unsigned release_depth(input int unsigned late);
    return (late != 0) ? 3 : 2;
  endfunction

  // Phase register update rule.
  function automatic logic phase_next(input logic held, input logic ph);
    return held ? 1'b1 : ~ph;
  endfunction

  // The edge that moves the phase from low to high captures data.
  function automatic logic is_capture_edge(input logic held, input logic ph);
    return (!held) && (!ph);
  endfunction

endpackage

// File: rtl/hr_reset_sync.sv
module hr_reset_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_async_i,
  output logic rst_sync_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk or posedge rst_async_i) begin
    if (rst_async_i) stage_q <= '1;
    else             stage_q <= {stage_q[DEPTH-2:0], 1'b0};
  end

  assign rst_sync_o = stage_q[LAST];

  // R2: once released, the synchronized reset stays released while the input stays low
  a_r2_release_sticks: assert property (@(posedge clk) disable iff (rst_async_i)
    !$past(rst_sync_o) |-> !rst_sync_o);

endmodule

// File: rtl/hr_phase_gen.sv
module hr_phase_gen
  import halfrate_pkg::*;
(
  input  logic clk,
  input  logic rst_i,
  output logic phase_o,
  output logic capture_o
);
  logic phase_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) phase_q <= 1'b1;
    else       phase_q <= phase_next(1'b0, phase_q);
  end

  assign phase_o   = phase_q;
  assign capture_o = is_capture_edge(rst_i, phase_q);

  // R3: phase inverts on every edge while held reset is low
  a_r3_toggle: assert property (@(posedge clk) disable iff (rst_i)
    !$past(rst_i) |-> (phase_q != $past(phase_q)));

  // R2: first edge counted after the internal release drives phase low
  a_r2_first_low: assert property (@(posedge clk) disable iff (rst_i)
    ($past(rst_i, 2) && !$past(rst_i)) |-> !phase_q);

endmodule

// File: rtl/hr_capture.sv
module hr_capture #(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture_i;
      if (capture_i) data_q <= din_i;
    end
  end

  assign dout_o  = data_q;
  assign valid_o = valid_q;

  // R5: valid never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst_i)
    valid_q |=> !valid_q);

  // R6: register holds across every non-capture edge
  a_r6_hold: assert property (@(posedge clk) disable iff (rst_i)
    !valid_q |-> $stable(data_q));

endmodule

// File: rtl/halfrate_latch.sv
module halfrate_latch
  import halfrate_pkg::*;
#(
  parameter int unsigned DATA_W       = 14,
  parameter int unsigned LATE_RELEASE = 0
) (
  input  logic              clk_fast,
  input  logic              rst_async,
  input  logic [DATA_W-1:0] din,
  output logic              phase_mon,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  localparam int unsigned SYNC_DEPTH = release_depth(LATE_RELEASE);

  logic held_rst;
  logic phase_w;
  logic capture_w;

  hr_reset_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk         (clk_fast),
    .rst_async_i (rst_async),
    .rst_sync_o  (held_rst)
  );

  hr_phase_gen u_phase (
    .clk       (clk_fast),
    .rst_i     (held_rst),
    .phase_o   (phase_w),
    .capture_o (capture_w)
  );

  hr_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk_fast),
    .rst_i     (held_rst),
    .capture_i (capture_w),
    .din_i     (din),
    .dout_o    (dout),
    .valid_o   (dout_valid)
  );

  assign phase_mon = phase_w;

  // R5: valid pulse coincides with a freshly risen phase
  a_r5_valid_on_rise: assert property (@(posedge clk_fast) disable iff (held_rst)
    dout_valid |-> (phase_w && !$past(phase_w)));

  // R4: every rise of the phase comes with a capture
  a_r4_rise_captures: assert property (@(posedge clk_fast) disable iff (held_rst)
    $rose(phase_w) |-> dout_valid);

endmodule

// File: tb/halfrate_latch_tb.sv
module halfrate_latch_tb;
  localparam int W = 14;
  localparam int S0 = 2;
  localparam int S1 = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst;
  logic [W-1:0] din;
  logic         ph0, v0, ph1, v1;
  logic [W-1:0] d0, d1;

  halfrate_latch #(.DATA_W(W), .LATE_RELEASE(0)) u_dut (
    .clk_fast(clk), .rst_async(rst), .din(din),
    .phase_mon(ph0), .dout(d0), .dout_valid(v0));

  halfrate_latch #(.DATA_W(W), .LATE_RELEASE(1)) u_dut_late (
    .clk_fast(clk), .rst_async(rst), .din(din),
    .phase_mon(ph1), .dout(d1), .dout_valid(v1));

  int n_tests = 0;
  int n_fail  = 0;
  int edges;
  bit done = 0;
  logic [W-1:0] q0[$];
  logic [W-1:0] q1[$];
  logic [W-1:0] last0, last1;

  always @(posedge clk or posedge rst)
    if (rst) edges <= 0; else edges <= edges + 1;

  function automatic bit exp_phase(int k, int s);
    if (k <= s) return 1'b1;
    return ((k - s) % 2) == 0;
  endfunction

  function automatic bit exp_cap(int k, int s);
    return (k > s) && (((k - s) % 2) == 0);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic mon(int idx, int s, logic ph, logic v, logic [W-1:0] d);
    logic [W-1:0] e;
    logic [W-1:0] last;
    string rq;
    last = (idx == 0) ? last0 : last1;
    if (rst) begin
      check(ph == 1'b1, "R1", "phase in reset", ph, 1);
      check(v == 1'b0, "R1", "valid in reset", v, 0);
      check(d == '0, "R1", "data in reset", d, 0);
      if (idx == 0) begin q0.delete(); last0 = '0; end
      else          begin q1.delete(); last1 = '0; end
      return;
    end
    rq = (idx == 1) ? "R8" : ((edges <= s) ? "R2" : "R3");
    check(ph == exp_phase(edges, s), rq, "phase", ph, exp_phase(edges, s));
    check(v == exp_cap(edges, s), "R5", "valid", v, exp_cap(edges, s));
    if (v) begin
      if (idx == 0) e = (q0.size() > 0) ? q0.pop_front() : '0;
      else          e = (q1.size() > 0) ? q1.pop_front() : '0;
      check(d == e, "R4", "captured data", d, e);
      if (idx == 0) last0 = d; else last1 = d;
    end else begin
      check(d == last, "R6", "held data", d, last);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      mon(0, S0, ph0, v0, d0);
      mon(1, S1, ph1, v1, d1);
    end
  end

  // Driver: sets the bus for the coming edge and queues expected captures.
  task automatic drive(logic [W-1:0] val);
    @(negedge clk);
    #1;
    din = val;
    if (!rst) begin
      if (exp_cap(edges + 1, S0)) q0.push_back(val);
      if (exp_cap(edges + 1, S1)) q1.push_back(val);
    end
  endtask

  task automatic set_rst(logic r);
    @(negedge clk);
    #1;
    rst = r;
    if (r) begin
      #1;
      check(ph0 == 1'b1 && ph1 == 1'b1, "R7", "async phase on reset", {ph0, ph1}, 3);
      check(!v0 && !v1, "R7", "async valid on reset", {v0, v1}, 0);
      check(d0 == '0 && d1 == '0, "R7", "async data clear", d0 | d1, 0);
    end
  endtask

  task automatic run(int mode, int n);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: drive(W'(i * 3 + 1));
        1: drive((i % 2) ? W'(14'h1555) : W'(14'h2AAA));
        2: drive(((i / 2) % 2) ? ((i % 2) ? '1 : '0) : ((i % 2) ? '0 : '1));
        default: drive(W'($urandom));
      endcase
    end
  endtask

  initial begin
    rst = 1'b1;
    din = '0;
    last0 = '0;
    last1 = '0;
    #1;
    check(ph0 == 1'b1 && ph1 == 1'b1, "R1", "phase at start", {ph0, ph1}, 3);
    check(d0 == '0 && !v0, "R1", "outputs at start", d0, 0);
    repeat (3) drive('0);
    set_rst(1'b0);
    run(0, 40);
    set_rst(1'b1);
    repeat (3) drive(14'h0F0F);
    set_rst(1'b0);
    run(1, 41);
    run(2, 40);
    set_rst(1'b1);
    repeat (2) drive(14'h3333);
    set_rst(1'b0);
    run(3, 60);
    set_rst(1'b1);
    run(3, 3);
    set_rst(1'b0);
    run(0, 21);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule